// File: doc/BRIEF.md
# DMA Service-Order Table Sequencer

This block decides which DMA channel, and in which direction, is serviced next. Software fills a table of packed entries through a simple register port. Each 32-bit table word holds four 8-bit entries, and each entry names a channel and says whether the transfer is a receive or a transmit. A control register enables the sequencer and sets the index of the last table entry that is in use. Software can therefore shape the service order freely. For example, it can give each channel a transmit slot followed by a receive slot, or it can give a busy channel more slots than the others.

While the sequencer is enabled, it presents the current entry as a valid channel and direction pair. Each advance pulse, given when the downstream arbiter grants the slot, moves the pointer to the next entry. After the last index the pointer goes back to entry 0. Writing zero to the control register stops the sequencer, and the pointer returns to entry 0.

The controller has two states. SCHED_OFF is the reset state: the pointer is held at 0 and no selection is valid. The *start* transition, taken when the enable bit is seen set, leads to SCHED_RUN. In SCHED_RUN the selection is valid and advance pulses step the pointer. The *stop* transition, taken when the enable bit is seen clear, returns to SCHED_OFF.

Top module: `dma_sched_seq`

## Requirements
- R1: After reset, `sel_valid` is 0 and the control register reads back as 0.
- R2: A write to byte address TBL_BASE + 4·w (default TBL_BASE = 0x800), for w below NUM_WORDS, stores the 32-bit table word w. A read of the same address returns that word on the clock edge that samples `reg_rd`.
- R3: The control register sits at address 0. Bit 31 is the enable, and bits IDX_W-1:0 hold the last entry index, where IDX_W = log2(4·NUM_WORDS). All other bits are not stored and read back as 0.
- R4: Entry e lives in word e/4, at bits 8k+7:8k with k = e mod 4. Bits 6:0 of the entry appear on `sel_chan`. Bit 7 appears on `sel_rx`, where 1 means receive and 0 means transmit.
- R5: After a write that sets the enable bit, `sel_valid` is still 0 after the first rising edge and becomes 1 after the second.
- R6: In SCHED_RUN, each cycle with `adv` high moves the pointer to the next entry, in order and across word boundaries. A cycle with `adv` low keeps the current entry.
- R7: An advance taken at the last index returns the pointer to entry 0.
- R8: `adv` has no effect in SCHED_OFF. The first entry presented after the *start* transition is entry 0.
- R9: Writing zero to the control register drops `sel_valid` two rising edges later. A later re-enable starts again at entry 0.
- R10: Writes to addresses outside the control register and the table, or to addresses that are not word-aligned, change nothing. Reads of such addresses return 0.
- R11: If the last index is lowered below the current pointer, the next advance returns the pointer to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| adv | input | 1 | Advance pulse: the current slot was granted |
| sel_valid | output | 1 | The current selection is valid |
| sel_chan | output | 7 | Channel number of the current entry |
| sel_rx | output | 1 | 1 = receive, 0 = transmit |

## Verification
The bench builds the block with NUM_WORDS = 8. This gives a 32-entry table and a 5-bit last-index field. With these values a full pass around the table, including the wrap at index 31, fits in a few dozen cycles. The first address beyond the table, 0x820, can then be used to probe the ignore rule for unmapped addresses. The smaller table also keeps it short to lower the last index below a pointer that has already advanced.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    localparam int ENTRY_W = 8;
    localparam int CHAN_W  = 7;
    localparam int WORD_W  = 32;
    localparam int ENT_PER_WORD = WORD_W / ENTRY_W;

    typedef enum logic [0:0] {
        SCHED_OFF = 1'b0,
        SCHED_RUN = 1'b1
    } sched_state_e;

    typedef struct packed {
        logic              rx;
        logic [CHAN_W-1:0] chan;
    } sched_entry_t;

endpackage

// File: rtl/dma_sched_regs.sv
module dma_sched_regs
    import dma_sched_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int ADDR_W    = 12,
    parameter int TBL_BASE  = 'h800,
    parameter int IDX_W     = $clog2(NUM_WORDS * ENT_PER_WORD)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic                        ctrl_en,
    output logic [IDX_W-1:0]            ctrl_last,
    output logic [NUM_WORDS*WORD_W-1:0] tbl_flat
);

    localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int TBL_END  = TBL_BASE + 4 * NUM_WORDS;
    localparam int EN_BIT   = WORD_W - 1;

    logic [WORD_W-1:0] tbl_q [NUM_WORDS];
    logic              ctrl_hit;
    logic              tbl_hit;
    logic [ADDR_W:0]   addr_ext;
    logic [ADDR_W:0]   tbl_off;
    logic [WIDX_W-1:0] widx;

    always_comb begin
        addr_ext = {1'b0, reg_addr};
        tbl_off  = addr_ext - (ADDR_W+1)'(TBL_BASE);
        ctrl_hit = (reg_addr == '0);
        tbl_hit  = (addr_ext >= (ADDR_W+1)'(TBL_BASE)) &&
                   (addr_ext <  (ADDR_W+1)'(TBL_END))  &&
                   (reg_addr[1:0] == 2'b00);
        widx     = tbl_off[WIDX_W+1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_last <= '0;
        end else if (reg_wr && ctrl_hit) begin
            ctrl_en   <= reg_wdata[EN_BIT];
            ctrl_last <= reg_wdata[IDX_W-1:0];
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic wr_this;
        assign wr_this = reg_wr && tbl_hit && (widx == WIDX_W'(w));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tbl_q[w] <= '0;
            else if (wr_this)
                tbl_q[w] <= reg_wdata;
        end
        assign tbl_flat[w*WORD_W +: WORD_W] = tbl_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd) begin
            if (ctrl_hit)
                reg_rdata <= {ctrl_en, {(WORD_W-1-IDX_W){1'b0}}, ctrl_last};
            else if (tbl_hit)
                reg_rdata <= tbl_q[widx];
            else
                reg_rdata <= '0;
        end
    end

endmodule

// File: rtl/dma_sched_fsm.sv
module dma_sched_fsm
    import dma_sched_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic [IDX_W-1:0] ctrl_last,
    input  logic             adv,
    output logic             run,
    output logic [IDX_W-1:0] ptr
);

    sched_state_e     state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    // next state and next pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            SCHED_OFF: begin
                ptr_d = '0;
                if (ctrl_en)
                    state_d = SCHED_RUN;      // start
            end
            SCHED_RUN: begin
                if (!ctrl_en) begin
                    state_d = SCHED_OFF;      // stop
                    ptr_d   = '0;
                end else if (adv) begin
                    if (ptr_q >= ctrl_last)
                        ptr_d = '0;
                    else
                        ptr_d = ptr_q + 1'b1;
                end
            end
            default: begin
                state_d = SCHED_OFF;
                ptr_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCHED_OFF;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        run = (state_q == SCHED_RUN);
        ptr = ptr_q;
    end

endmodule

// File: rtl/dma_sched_mux.sv
module dma_sched_mux
    import dma_sched_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = $clog2(NUM_WORDS * ENT_PER_WORD)
) (
    input  logic [NUM_WORDS*WORD_W-1:0] tbl_flat,
    input  logic [IDX_W-1:0]            ptr,
    output sched_entry_t                cur
);

    localparam int NUM_ENT = NUM_WORDS * ENT_PER_WORD;

    sched_entry_t ent_arr [NUM_ENT];

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        assign ent_arr[e] = sched_entry_t'(tbl_flat[e*ENTRY_W +: ENTRY_W]);
    end

    assign cur = ent_arr[ptr];

endmodule

// File: rtl/dma_sched_seq.sv
module dma_sched_seq
    import dma_sched_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int ADDR_W    = 12,
    parameter int TBL_BASE  = 'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              adv,
    output logic              sel_valid,
    output logic [6:0]        sel_chan,
    output logic              sel_rx
);

    localparam int IDX_W = $clog2(NUM_WORDS * ENT_PER_WORD);

    logic                        ctrl_en_w;
    logic [IDX_W-1:0]            last_w;
    logic [IDX_W-1:0]            ptr_w;
    logic                        run_w;
    logic [NUM_WORDS*WORD_W-1:0] tbl_w;
    sched_entry_t                cur_w;

    dma_sched_regs #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .TBL_BASE  (TBL_BASE),
        .IDX_W     (IDX_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_en   (ctrl_en_w),
        .ctrl_last (last_w),
        .tbl_flat  (tbl_w)
    );

    dma_sched_fsm #(
        .IDX_W (IDX_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_en   (ctrl_en_w),
        .ctrl_last (last_w),
        .adv       (adv),
        .run       (run_w),
        .ptr       (ptr_w)
    );

    dma_sched_mux #(
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) mux_i (
        .tbl_flat (tbl_w),
        .ptr      (ptr_w),
        .cur      (cur_w)
    );

    assign sel_valid = run_w;
    assign sel_chan  = cur_w.chan;
    assign sel_rx    = cur_w.rx;

endmodule

// File: rtl/dma_sched_seq_chk.sv
module dma_sched_seq_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ctrl_en,
    input logic             adv,
    input logic [IDX_W-1:0] ptr,
    input logic [IDX_W-1:0] last,
    input logic             sel_valid
);

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_en && adv && ptr < last) |=> (ptr == $past(ptr) + 1'b1));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_en && adv && ptr >= last) |=> (ptr == '0));

    // R6
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_en && !adv) |=> $stable(ptr));

    // R8
    off_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (ptr == '0));

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_valid) |-> $past(ctrl_en));

    // R9
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_valid) |-> !$past(ctrl_en));

endmodule

bind dma_sched_seq dma_sched_seq_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .ctrl_en   (ctrl_en_w),
    .adv       (adv),
    .ptr       (ptr_w),
    .last      (last_w),
    .sel_valid (sel_valid)
);

// File: tb/dma_sched_seq_tb_top.sv
module dma_sched_seq_tb_top;

    localparam int NW    = 8;
    localparam int NENT  = NW * 4;
    localparam int AW    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adv = 1'b0;
    logic        sel_valid;
    logic [6:0]  sel_chan;
    logic        sel_rx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int model_p = 0;
    int model_last = 0;

    logic [8:0] exp_q [$];

    always #5 clk = ~clk;

    dma_sched_seq #(.NUM_WORDS(NW), .ADDR_W(AW), .TBL_BASE('h800)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adv(adv), .sel_valid(sel_valid), .sel_chan(sel_chan), .sel_rx(sel_rx)
    );

    function automatic logic [7:0] ent(int e);
        logic [6:0] c;
        c = 7'((e * 5 + 3) % 128);
        return {(e % 3 == 0) ? 1'b1 : 1'b0, c};
    endfunction

    function automatic logic [31:0] word_of(int w);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = ent(4*w + k);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // driver: push the expected current entry, then request an advance
    task automatic drive_steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exp_q.push_back({1'b1, ent(model_p)});
            adv = 1'b1;
            model_p = (model_p >= model_last) ? 0 : model_p + 1;
        end
        @(negedge clk);
        adv = 1'b0;
    endtask

    // monitor: compare the presented selection against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [8:0] e;
                e = exp_q.pop_front();
                // R4 R6 R7 R11
                chk({sel_valid, sel_rx, sel_chan} == e, "R4/R6/R7/R11 sequence",
                    32'({sel_valid, sel_rx, sel_chan}), 32'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(sel_valid == 1'b0, "R1 valid after reset", 32'(sel_valid), 0);
        reg_read('0, rd);
        chk(rd == 0, "R1 ctrl after reset", rd, 0);

        // R2
        for (int w = 0; w < NW; w++) reg_write(AW'('h800 + 4*w), word_of(w));
        for (int w = 0; w < NW; w++) begin
            reg_read(AW'('h800 + 4*w), rd);
            chk(rd == word_of(w), "R2 table readback", rd, word_of(w));
        end

        // R10
        reg_write(AW'('h820), 32'hDEAD_BEEF);
        reg_read(AW'('h820), rd);
        chk(rd == 0, "R10 unmapped read", rd, 0);
        reg_write(AW'('h802), 32'h1234_5678);
        reg_read(AW'('h800), rd);
        chk(rd == word_of(0), "R10 misaligned write ignored", rd, word_of(0));
        reg_write(AW'('h004), 32'h8000_0001);
        chk(sel_valid == 1'b0, "R10 stray write no enable", 32'(sel_valid), 0);

        // R8
        @(negedge clk); adv = 1'b1;
        repeat (3) @(negedge clk);
        adv = 1'b0;
        chk(sel_valid == 1'b0, "R8 adv while off", 32'(sel_valid), 0);

        // R3 and R5
        model_last = NENT - 1;
        reg_write('0, 32'h80FF_FF00 | 32'(NENT - 1));
        chk(sel_valid == 1'b0, "R5 not valid after first edge", 32'(sel_valid), 0);
        @(negedge clk);
        chk(sel_valid == 1'b1, "R5 valid after second edge", 32'(sel_valid), 1);
        // R8: first entry after start is 0
        chk({sel_rx, sel_chan} == ent(0), "R8 start at entry 0", 32'({sel_rx, sel_chan}), 32'(ent(0)));
        reg_read('0, rd);
        chk(rd == (32'h8000_0000 | 32'(NENT - 1)), "R3 ctrl readback", rd, 32'h8000_0000 | 32'(NENT - 1));

        // R6 hold without adv
        repeat (2) @(negedge clk);
        chk({sel_rx, sel_chan} == ent(0), "R6 hold without adv", 32'({sel_rx, sel_chan}), 32'(ent(0)));

        // R6 R7: full pass with wrap
        model_p = 0;
        drive_steps(NENT + 8);

        // R11: lower last below current pointer
        model_last = 3;
        reg_write('0, 32'h8000_0003);
        drive_steps(6);

        // R9
        reg_write('0, 32'h0);
        chk(sel_valid == 1'b1, "R9 valid one edge after disable", 32'(sel_valid), 1);
        @(negedge clk);
        chk(sel_valid == 1'b0, "R9 valid dropped", 32'(sel_valid), 0);
        model_last = NENT - 1;
        model_p = 0;
        reg_write('0, 32'h8000_0000 | 32'(NENT - 1));
        @(negedge clk);
        chk({sel_valid, sel_rx, sel_chan} == {1'b1, ent(0)}, "R9 restart at entry 0",
            32'({sel_valid, sel_rx, sel_chan}), 32'({1'b1, ent(0)}));
        drive_steps(5);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule